// File: doc/BRIEF.md
# Cache Memory Access Type Selector

This block sits between a data cache and its memory bus. It receives one memory request at a time and turns it into a short sequence of bus transactions. A request is either a read or a write, at a byte address. For a write-back eviction it also carries a per-word valid mask. Three configuration inputs steer the choice: the write policy, whether the cache is enabled, and whether the bus carries one 32-bit word per beat (narrow) or a whole line (wide). The result is one line burst, one single-word access, or a series of single-word accesses, each with its own address.

When the cache is disabled, a read is returned to the requester. Some of these reads fetch a whole line as a burst. In that case the block keeps only the beat that holds the requested word and drops the others. The block signals the end of the complete sequence with a one-cycle done pulse. It takes the next request in that same cycle at the earliest.

Transactions are offered with a valid/ready pair. Each is followed by its data beats, which the bus reports through `beat_valid_i`. Beats are counted in words: a burst has WPL beats and a single access has one.

Top module: `acc_sel`

## Requirements
- R1: Write-through with the cache enabled: a read issues one burst of WPL beats at the line-aligned address (`txn_burst_o`=1, `txn_len_o`=WPL). A write issues one single access (`txn_len_o`=1) at the word-aligned request address.
- R2: Write-back with the cache enabled: a read issues one line-aligned burst of WPL beats.
- R3: Write-back, cache enabled, wide bus: the write-out of a line whose valid mask is all ones issues one burst with `txn_mask_o` all ones.
- R4: Write-back, cache enabled, wide bus, partly valid line: the block issues one single access per valid word, in ascending word order, at line base + index*DW/8. An all-zero mask issues nothing and pulses `done_o` in the cycle after acceptance.
- R5: Write-back, cache enabled, narrow bus: a line write-out with two or more valid words issues one burst whose `txn_mask_o` equals the valid mask (bit i = word i). Exactly one valid word gives one single access at that word's address. No valid word gives no transaction.
- R6: With the cache disabled, every write is one single access at the word-aligned request address, for either policy and either bus width.
- R7: Write-through with the cache disabled: a read issues a line burst. `rd_data_o` is the beat whose index equals the word offset of the request address within the line, presented with `rd_valid_o`.
- R8: Write-back with the cache disabled: a read on a narrow bus is a discarding burst as in R7. On a wide bus it is one single access whose only beat is returned on `rd_data_o`.
- R9: While `txn_valid_o` is high and `txn_ready_i` is low, the address, length, kind and mask stay unchanged. `req_ready_o` is high only when no sequence is in progress.
- R10: `done_o` rises in the cycle after the last beat of the last transaction, with `req_ready_o` high in that cycle. `rd_valid_o` is only ever high together with `done_o`.
- R11: After reset, `req_ready_o`=1 and `txn_valid_o`, `done_o` and `rd_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high with req_valid_i |
| req_write_i | input | 1 | 1 = write or line write-out, 0 = read |
| req_addr_i | input | AW | Request byte address |
| req_mask_i | input | WPL | Per-word valid mask of the line written out |
| cfg_wb_i | input | 1 | 1 = write-back policy, 0 = write-through |
| cfg_en_i | input | 1 | Cache enabled |
| cfg_narrow_i | input | 1 | 1 = 32-bit bus, 0 = line-wide bus |
| txn_valid_o | output | 1 | Transaction offered |
| txn_ready_i | input | 1 | Bus takes the transaction |
| txn_burst_o | output | 1 | 1 = line burst, 0 = single access |
| txn_write_o | output | 1 | Transaction direction |
| txn_addr_o | output | AW | Transaction byte address |
| txn_len_o | output | $clog2(WPL+1) | Beat count (1 or WPL) |
| txn_mask_o | output | WPL | Word enables for a burst write, all ones otherwise |
| beat_valid_i | input | 1 | One data beat completed |
| beat_data_i | input | DW | Read data of the beat |
| done_o | output | 1 | Sequence finished (one cycle) |
| rd_valid_o | output | 1 | Uncached read word valid |
| rd_data_o | output | DW | Uncached read word |

## Verification
The done pulse that closes one sequence and the acceptance of the next request fall in the same cycle. The bench presents each new request in the exact cycle where it expects `done_o`. It then checks that `done_o`, `rd_valid_o`, the returned word and `req_ready_o` are all correct in that cycle, and that the following transaction is offered one cycle later. Multi-word write-outs also put the last beat of one single access right before the issue of the next. This exercises the reload of the next valid word index against the end of the beat count.

// File: rtl/acc_sel_pkg.sv
package acc_sel_pkg;
  typedef enum logic [1:0] {SEQ_NONE, SEQ_BURST, SEQ_SINGLE, SEQ_WORDS} seq_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DATA} seq_state_e;
endpackage

// File: rtl/acc_plan_dec.sv
module acc_plan_dec
  import acc_sel_pkg::*;
#(
  parameter int WPL = 8
) (
  input  logic           wb_i,
  input  logic           en_i,
  input  logic           narrow_i,
  input  logic           write_i,
  input  logic [WPL-1:0] mask_i,
  output seq_kind_e      kind_o,
  output logic           capture_o
);
  logic full_w, any_w, multi_w;

  assign full_w  = &mask_i;
  assign any_w   = |mask_i;
  assign multi_w = |(mask_i & (mask_i - WPL'(1)));

  always_comb begin
    kind_o    = SEQ_SINGLE;
    capture_o = 1'b0;
    if (write_i) begin
      if (en_i && wb_i) begin
        if (narrow_i) kind_o = multi_w ? SEQ_BURST : (any_w ? SEQ_WORDS : SEQ_NONE);
        else          kind_o = full_w  ? SEQ_BURST : (any_w ? SEQ_WORDS : SEQ_NONE);
      end
    end else if (en_i) begin
      kind_o = SEQ_BURST;
    end else begin
      capture_o = 1'b1;
      kind_o    = (wb_i && !narrow_i) ? SEQ_SINGLE : SEQ_BURST;
    end
  end
endmodule

// File: rtl/acc_first_word.sv
module acc_first_word #(
  parameter int WPL  = 8,
  parameter int OFFW = $clog2(WPL)
) (
  input  logic [WPL-1:0]  mask_i,
  output logic            found_o,
  output logic [OFFW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = WPL - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        found_o = 1'b1;
        idx_o   = OFFW'(i);
      end
    end
  end
endmodule

// File: rtl/acc_beat_pick.sv
module acc_beat_pick #(
  parameter int DW   = 32,
  parameter int OFFW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            beat_valid_i,
  input  logic [OFFW-1:0] beat_idx_i,
  input  logic [OFFW-1:0] want_idx_i,
  input  logic [DW-1:0]   beat_data_i,
  output logic [DW-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else if (en_i && beat_valid_i && beat_idx_i == want_idx_i) data_o <= beat_data_i;
  end
endmodule

// File: rtl/acc_sel.sv
module acc_sel
  import acc_sel_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int WPL  = 8,
  parameter int LENW = $clog2(WPL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [WPL-1:0]  req_mask_i,
  input  logic            cfg_wb_i,
  input  logic            cfg_en_i,
  input  logic            cfg_narrow_i,
  output logic            txn_valid_o,
  input  logic            txn_ready_i,
  output logic            txn_burst_o,
  output logic            txn_write_o,
  output logic [AW-1:0]   txn_addr_o,
  output logic [LENW-1:0] txn_len_o,
  output logic [WPL-1:0]  txn_mask_o,
  input  logic            beat_valid_i,
  input  logic [DW-1:0]   beat_data_i,
  output logic            done_o,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o
);
  localparam int BOFF   = $clog2(DW / 8);
  localparam int OFFW   = $clog2(WPL);
  localparam int LINE_B = BOFF + OFFW;

  seq_state_e      state_q;
  seq_kind_e       kind_q, plan_kind;
  logic            plan_capture, capture_q, write_q, burst_q, done_q, rd_valid_q;
  logic [AW-1:0]   addr_q, base_q, line_base, word_addr;
  logic [WPL-1:0]  rem_q, mask_q, fw_mask;
  logic [OFFW-1:0] fw_idx, want_q;
  logic            fw_found;
  logic [LENW-1:0] len_q, beat_cnt_q;
  logic            last_beat;

  assign line_base = {req_addr_i[AW-1:LINE_B], {LINE_B{1'b0}}};
  assign word_addr = {req_addr_i[AW-1:BOFF], {BOFF{1'b0}}};
  assign fw_mask   = (state_q == ST_IDLE) ? req_mask_i : rem_q;
  assign last_beat = beat_cnt_q == len_q - LENW'(1);

  acc_plan_dec #(.WPL(WPL)) u_plan (
    .wb_i(cfg_wb_i), .en_i(cfg_en_i), .narrow_i(cfg_narrow_i),
    .write_i(req_write_i), .mask_i(req_mask_i),
    .kind_o(plan_kind), .capture_o(plan_capture)
  );

  acc_first_word #(.WPL(WPL), .OFFW(OFFW)) u_first (
    .mask_i(fw_mask), .found_o(fw_found), .idx_o(fw_idx)
  );

  acc_beat_pick #(.DW(DW), .OFFW(OFFW)) u_pick (
    .clk_i, .rst_ni,
    .en_i(capture_q && state_q == ST_DATA),
    .beat_valid_i, .beat_idx_i(beat_cnt_q[OFFW-1:0]),
    .want_idx_i(want_q), .beat_data_i, .data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= SEQ_NONE;
      capture_q  <= 1'b0;
      write_q    <= 1'b0;
      burst_q    <= 1'b0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      addr_q     <= '0;
      base_q     <= '0;
      rem_q      <= '0;
      mask_q     <= '0;
      want_q     <= '0;
      len_q      <= '0;
      beat_cnt_q <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          kind_q    <= plan_kind;
          capture_q <= plan_capture;
          write_q   <= req_write_i;
          base_q    <= line_base;
          want_q    <= (plan_kind == SEQ_SINGLE) ? '0 : req_addr_i[LINE_B-1:BOFF];
          mask_q    <= '1;
          unique case (plan_kind)
            SEQ_NONE: done_q <= 1'b1;
            SEQ_BURST: begin
              addr_q  <= line_base;
              len_q   <= LENW'(WPL);
              burst_q <= 1'b1;
              if (req_write_i) mask_q <= req_mask_i;
              state_q <= ST_ISSUE;
            end
            SEQ_SINGLE: begin
              addr_q  <= word_addr;
              len_q   <= LENW'(1);
              burst_q <= 1'b0;
              state_q <= ST_ISSUE;
            end
            default: begin
              addr_q  <= {req_addr_i[AW-1:LINE_B], fw_idx, {BOFF{1'b0}}};
              rem_q   <= req_mask_i & ~(WPL'(1) << fw_idx);
              len_q   <= LENW'(1);
              burst_q <= 1'b0;
              state_q <= ST_ISSUE;
            end
          endcase
        end
        ST_ISSUE: if (txn_ready_i) begin
          beat_cnt_q <= '0;
          state_q    <= ST_DATA;
        end
        ST_DATA: if (beat_valid_i) begin
          beat_cnt_q <= beat_cnt_q + LENW'(1);
          if (last_beat) begin
            if (kind_q == SEQ_WORDS && fw_found) begin
              addr_q  <= {base_q[AW-1:LINE_B], fw_idx, {BOFF{1'b0}}};
              rem_q   <= rem_q & ~(WPL'(1) << fw_idx);
              state_q <= ST_ISSUE;
            end else begin
              done_q     <= 1'b1;
              rd_valid_q <= capture_q;
              state_q    <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = state_q == ST_IDLE;
  assign txn_valid_o = state_q == ST_ISSUE;
  assign txn_burst_o = burst_q;
  assign txn_write_o = write_q;
  assign txn_addr_o  = addr_q;
  assign txn_len_o   = len_q;
  assign txn_mask_o  = mask_q;
  assign done_o      = done_q;
  assign rd_valid_o  = rd_valid_q;

  // R9: offer is held until taken
  a_r9_offer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) &&
    $stable(txn_len_o) && $stable(txn_burst_o) && $stable(txn_mask_o));

  a_r9_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !txn_valid_o);

  a_r10_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  a_r10_rdv_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> done_o);

  // R1/R2: bursts cover a full aligned line
  a_r2_burst_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_burst_o |->
    txn_len_o == LENW'(WPL) && txn_addr_o[LINE_B-1:0] == '0);

  a_r6_single_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_burst_o |-> txn_len_o == LENW'(1));

  a_r5_burst_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_burst_o && txn_write_o |-> $countones(txn_mask_o) >= 2);
endmodule

// File: tb/acc_sel_tb.sv
module acc_sel_tb_top;
  localparam int AW = 32, DW = 32, WPL = 8, LENW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0, wb = 0, en = 0, nar = 0;
  logic [AW-1:0] req_addr = '0;
  logic [WPL-1:0] req_mask = '0;
  logic txn_ready = 0, beat_valid = 0;
  logic [DW-1:0] beat_data = '0;
  logic req_ready, txn_valid, txn_burst, txn_write, done, rd_valid;
  logic [AW-1:0] txn_addr;
  logic [LENW-1:0] txn_len;
  logic [WPL-1:0] txn_mask;
  logic [DW-1:0] rd_data;

  acc_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_mask_i(req_mask),
    .cfg_wb_i(wb), .cfg_en_i(en), .cfg_narrow_i(nar),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready), .txn_burst_o(txn_burst),
    .txn_write_o(txn_write), .txn_addr_o(txn_addr), .txn_len_o(txn_len),
    .txn_mask_o(txn_mask), .beat_valid_i(beat_valid), .beat_data_i(beat_data),
    .done_o(done), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  typedef struct {
    logic [AW-1:0]  addr;
    int             len;
    bit             burst;
    bit             wr;
    logic [WPL-1:0] mask;
  } txn_t;

  txn_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit exp_cap;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return 32'hA500_0000 ^ a;
  endfunction

  function automatic void push(logic [AW-1:0] a, int l, bit b, bit w, logic [WPL-1:0] m);
    txn_t t;
    t.addr = a; t.len = l; t.burst = b; t.wr = w; t.mask = m;
    exp_q.push_back(t);
  endfunction

  // behavioural model of the selection rules
  function automatic void build(bit w, logic [AW-1:0] a, logic [WPL-1:0] m, bit p_wb, bit p_en, bit p_nar);
    logic [AW-1:0] wa = {a[AW-1:2], 2'b0};
    logic [AW-1:0] base = {a[AW-1:5], 5'b0};
    int cnt = $countones(m);
    exp_cap = 0;
    if (w) begin
      if (p_en && p_wb) begin
        if ((p_nar && cnt >= 2) || (!p_nar && cnt == WPL)) push(base, WPL, 1, 1, m);
        else for (int i = 0; i < WPL; i++) if (m[i]) push(base + AW'(4 * i), 1, 0, 1, '1);
      end else push(wa, 1, 0, 1, '1);
    end else if (p_en) push(base, WPL, 1, 0, '1);
    else begin
      exp_cap = 1;
      if (p_wb && !p_nar) push(wa, 1, 0, 0, '1);
      else push(base, WPL, 1, 0, '1);
    end
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge where done is expected
  task automatic run(string tag, bit w, logic [AW-1:0] a, logic [WPL-1:0] m, bit p_wb, bit p_en, bit p_nar);
    logic [AW-1:0] wa = {a[AW-1:2], 2'b0};
    build(w, a, m, p_wb, p_en, p_nar);
    req_valid = 1; req_write = w; req_addr = a; req_mask = m;
    wb = p_wb; en = p_en; nar = p_nar;
    chk({tag, " R9 accept ready"}, 64'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    if (exp_q.size() == 0) begin
      chk({tag, " R4/R5 empty done"}, 64'(done), 1);
      chk({tag, " R4/R5 no txn"}, 64'(txn_valid), 0);
      return;
    end
    foreach (exp_q[i]) begin
      txn_t t = exp_q[i];
      chk({tag, " txn valid"}, 64'(txn_valid), 1);
      chk({tag, " R9 busy"}, 64'(req_ready), 0);
      chk({tag, " txn burst"}, 64'(txn_burst), 64'(t.burst));
      chk({tag, " txn addr"}, 64'(txn_addr), 64'(t.addr));
      chk({tag, " txn len"}, 64'(txn_len), 64'(t.len));
      chk({tag, " txn write"}, 64'(txn_write), 64'(t.wr));
      chk({tag, " txn mask"}, 64'(txn_mask), 64'(t.mask));
      chk({tag, " R10 no early done"}, 64'(done), 0);
      if (i == 0) begin
        @(negedge clk);
        chk({tag, " R9 held valid"}, 64'(txn_valid), 1);
        chk({tag, " R9 held addr"}, 64'(txn_addr), 64'(t.addr));
      end
      txn_ready = 1;
      @(negedge clk);
      txn_ready = 0;
      for (int k = 0; k < t.len; k++) begin
        if (k == 1) @(negedge clk);
        beat_valid = 1;
        beat_data = pat(t.addr + AW'(4 * k));
        @(negedge clk);
        beat_valid = 0;
      end
    end
    chk({tag, " R10 done"}, 64'(done), 1);
    chk({tag, " R10 ready at done"}, 64'(req_ready), 1);
    chk({tag, " R10 rd_valid"}, 64'(rd_valid), 64'(exp_cap));
    if (exp_cap) chk({tag, " R7/R8 rd_data"}, 64'(rd_data), 64'(pat(wa)));
    exp_q.delete();
  endtask

  // every-clock monitor
  always @(negedge clk) if (rst_n) begin
    if (rd_valid && !done) chk("R10 rd_valid without done", 0, 1);
    if (req_ready && txn_valid) chk("R9 ready while offering", 1, 0);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    chk("R11 reset ready", 64'(req_ready), 1);
    chk("R11 reset txn_valid", 64'(txn_valid), 0);
    chk("R11 reset done", 64'(done), 0);
    chk("R11 reset rd_valid", 64'(rd_valid), 0);
    rst_n = 1;
    idle(2);
    run("R1 wt rd", 0, 32'h1000_0014, 8'h00, 0, 1, 0);
    run("R1 wt wr", 1, 32'h2000_000A, 8'h00, 0, 1, 1);
    chk("R10 done single pulse", 64'(done), 1);
    idle(1);
    chk("R10 done dropped", 64'(done), 0);
    run("R2 wb rd", 0, 32'h3000_003C, 8'h00, 1, 1, 0);
    run("R3 wb full", 1, 32'h4000_0040, 8'hFF, 1, 1, 0);
    run("R4 wb partial", 1, 32'h4100_0060, 8'hA6, 1, 1, 0);
    run("R4 wb one", 1, 32'h4100_0080, 8'h80, 1, 1, 0);
    run("R4 wb empty", 1, 32'h4200_0000, 8'h00, 1, 1, 0);
    run("R5 narrow burst", 1, 32'h4300_0020, 8'h81, 1, 1, 1);
    run("R5 narrow one", 1, 32'h4400_0000, 8'h10, 1, 1, 1);
    run("R5 narrow empty", 1, 32'h4500_0000, 8'h00, 1, 1, 1);
    idle(2);
    run("R6 off wb wr", 1, 32'h5000_0006, 8'hFF, 1, 0, 0);
    run("R6 off wt wr", 1, 32'h5100_001F, 8'h00, 0, 0, 1);
    run("R7 off wt rd5", 0, 32'h6000_0014, 8'h00, 0, 0, 0);
    run("R7 off wt rd0", 0, 32'h6000_0100, 8'h00, 0, 0, 1);
    run("R7 off wt rd7", 0, 32'h6000_01FC, 8'h00, 0, 0, 0);
    idle(1);
    run("R8 off wb nar", 0, 32'h7000_0008, 8'h00, 1, 0, 1);
    run("R8 off wb wide", 0, 32'h7100_0018, 8'h00, 1, 0, 0);
    idle(2);
    summary();
    $finish;
  end
endmodule